// File: doc/BRIEF.md
# Linear Page Table TLB Refill Engine

This block services TLB misses for user addresses. The page table entries sit in a linear array that lives in virtual space. When a miss arrives, the engine scales the faulting page number by the 8-byte entry size and adds the linear table base. The result is the virtual address of the wanted entry. The engine then asks the TLB whether the page holding that entry is already mapped. If it is, one physical read fetches the entry, and the user translation is written into the TLB.

If the table page has no translation, the engine handles a nested miss. It walks a two-level system table held in physical memory, installs a mapping for the table page and then performs the entry fetch. The mapping for the table page carries protection bits that the engine generates from the mode of the faulting access. Because of this, later misses on pages whose entries share that table page cost only one read.

A clear valid bit at any stage ends the refill with a fault response and installs nothing. An address with bits set above the user range is refused at once. The TLB array is outside the block. It answers lookups in the same cycle and takes installs on a write strobe.

Top module: `lpt_refill`

## Requirements
- R1: After reset the engine is idle: `miss_ready_o` is 1, and `mem_req_o`, `tlb_lkup_o`, `tlb_wr_o` and `resp_valid_o` are 0. While idle it issues no read and no install.
- R2: A miss whose address has any of bits 63:43 set is answered with `resp_valid_o`=1 and `resp_fault_o`=1 in the cycle after acceptance. It causes no lookup, no read and no install.
- R3: For an accepted user address, the engine first looks up the table page VPN. This is bits 63:13 of `ptbase_i + (va[42:13] << 3)`, called the entry address.
- R4: If the lookup hits, the engine issues exactly one read, at `{hit_pfn, entry_addr[12:0]}`.
- R5: If the lookup misses, the engine reads two locations in order. The first is `sysbase_i + entry_addr[32:23]*8`. The second is `{first_pte[39:13], 13'b0} + entry_addr[22:13]*8`.
- R6: After a successful two-level walk, the engine installs the table page before the entry fetch. The install uses VPN = entry_addr[63:13], PFN = second_pte[39:13] and protection `{miss_kern_i, 1'b0, 1'b1}`. The entry fetch then uses this PFN.
- R7: A PTE has valid in bit 0, protection in bits 3:1 and PFN in bits 39:13. After a valid entry fetch, the engine installs VPN = va[42:13], PFN = pte[39:13] and protection = pte[3:1]. In that same cycle it returns `resp_valid_o`=1 and `resp_fault_o`=0.
- R8: If any PTE read (first level, second level or entry) has bit 0 clear, the engine stops with a fault response and makes no further read and no further install.
- R9: `mem_req_o` is a one-cycle pulse. No new read starts while one is outstanding. `miss_ready_o` stays 0 from acceptance until the response has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptbase_i | input | 64 | Virtual base of the linear table (8 GiB aligned) |
| sysbase_i | input | PA_W | Physical base of the first-level system table |
| miss_valid_i | input | 1 | TLB miss request |
| miss_va_i | input | 64 | Faulting virtual address |
| miss_kern_i | input | 1 | Faulting access was in kernel mode |
| miss_ready_o | output | 1 | Engine idle, miss accepted |
| resp_valid_o | output | 1 | Refill finished (one cycle) |
| resp_fault_o | output | 1 | Refill ended in a fault |
| tlb_lkup_o | output | 1 | TLB lookup strobe |
| tlb_lkup_vpn_o | output | 51 | VPN looked up |
| tlb_hit_i | input | 1 | Lookup hit (same cycle) |
| tlb_hit_pfn_i | input | PA_W-13 | PFN on a hit |
| tlb_wr_o | output | 1 | TLB install strobe |
| tlb_wr_vpn_o | output | 51 | VPN to install |
| tlb_wr_pfn_o | output | PA_W-13 | PFN to install |
| tlb_wr_prot_o | output | 3 | Protection to install |
| mem_req_o | output | 1 | Physical read request |
| mem_addr_o | output | PA_W | Read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |

## Verification
The first miss lands in a table page that is not mapped. This must produce the full nested sequence: lookup, two system reads, the table-page install, the fetch and the user install. Later misses in the same page, including the last entry slot of the page, must cost one read. A miss one entry past that page must trigger a new walk.

Other misses cover clear valid bits at the first level, the second level and the entry, and addresses with high bits set. Each shows exactly where the engine stops. A kernel-mode nested miss separates the generated protection from values read from memory. Read latencies of one to three cycles show that the engine waits for data rather than counting cycles.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int VA_W    = 64;
  localparam int PG_SH   = 13;
  localparam int VPN_W   = VA_W - PG_SH;
  localparam int UVPN_HI = 42;
  localparam int UVPN_W  = UVPN_HI - PG_SH + 1;
  localparam int HI_W    = VA_W - UVPN_HI - 1;
  localparam int ENT_SH  = 3;
  localparam int IDX_W   = 10;
  localparam int L1_LSB  = PG_SH + IDX_W;
  localparam int L2_LSB  = PG_SH;
  localparam int PTE_W   = 64;
  localparam int PROT_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_WALK1, ST_WALK2,
    ST_TBL_INST, ST_FETCH, ST_USR_INST, ST_FAULT
  } seq_state_e;

  typedef enum logic [1:0] {SEL_L1, SEL_L2, SEL_PTE} addr_sel_e;
endpackage

// File: rtl/lpt_addr_gen.sv
module lpt_addr_gen
  import lpt_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic [HI_W-1:0]       va_hi_i,
  input  logic [UVPN_W-1:0]     uvpn_i,
  input  logic [VA_W-1:0]       ptbase_i,
  input  logic [PA_W-1:0]       sysbase_i,
  input  logic [PA_W-PG_SH-1:0] l2_pfn_i,
  input  logic [PA_W-PG_SH-1:0] tbl_pfn_i,
  input  addr_sel_e             sel_i,
  output logic                  va_ok_o,
  output logic [VPN_W-1:0]      tbl_vpn_o,
  output logic [PA_W-1:0]       addr_o
);
  logic [VA_W-1:0] ent_va;
  logic [PA_W-1:0] l1_a, l2_a, pte_a;

  assign va_ok_o   = (va_hi_i == '0);
  assign ent_va    = ptbase_i + (VA_W'(uvpn_i) << ENT_SH);
  assign tbl_vpn_o = ent_va[VA_W-1:PG_SH];
  assign l1_a      = sysbase_i + (PA_W'(ent_va[L1_LSB +: IDX_W]) << ENT_SH);
  assign l2_a      = {l2_pfn_i, {PG_SH{1'b0}}} + (PA_W'(ent_va[L2_LSB +: IDX_W]) << ENT_SH);
  assign pte_a     = {tbl_pfn_i, ent_va[PG_SH-1:0]};

  always_comb begin
    case (sel_i)
      SEL_L1:  addr_o = l1_a;
      SEL_L2:  addr_o = l2_a;
      default: addr_o = pte_a;
    endcase
  end
endmodule

// File: rtl/lpt_seq.sv
module lpt_seq
  import lpt_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  miss_valid_i,
  input  logic                  miss_kern_i,
  input  logic                  va_ok_i,
  input  logic                  lkup_hit_i,
  input  logic [PA_W-PG_SH-1:0] lkup_pfn_i,
  input  logic                  rvalid_i,
  input  logic [PTE_W-1:0]      rdata_i,
  output logic                  ready_o,
  output logic                  accept_o,
  output logic                  lkup_o,
  output logic                  mem_req_o,
  output addr_sel_e             sel_o,
  output logic                  tbl_wr_o,
  output logic                  usr_wr_o,
  output logic                  resp_valid_o,
  output logic                  resp_fault_o,
  output logic                  kern_o,
  output logic [PA_W-PG_SH-1:0] l2_pfn_o,
  output logic [PA_W-PG_SH-1:0] tbl_pfn_o,
  output logic [PA_W-PG_SH-1:0] usr_pfn_o,
  output logic [PROT_W-1:0]     usr_prot_o
);
  localparam int PFN_W = PA_W - PG_SH;

  seq_state_e        st_q, st_d;
  logic              sent_q, kern_q;
  logic [PFN_W-1:0]  l2_pfn_q, tbl_pfn_q, usr_pfn_q;
  logic [PROT_W-1:0] usr_prot_q;
  logic              mem_st, rd_done, rd_ok;
  logic [PFN_W-1:0]  rd_pfn;
  logic              unused_rdata;

  assign mem_st    = (st_q == ST_WALK1) || (st_q == ST_WALK2) || (st_q == ST_FETCH);
  assign mem_req_o = mem_st && !sent_q;
  assign rd_done   = mem_st && sent_q && rvalid_i;
  assign rd_ok     = rdata_i[0];
  assign rd_pfn    = rdata_i[PA_W-1:PG_SH];
  assign unused_rdata = ^{rdata_i[PTE_W-1:PA_W], rdata_i[PG_SH-1:PROT_W+1]};

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (miss_valid_i) st_d = va_ok_i ? ST_LOOKUP : ST_FAULT;
      ST_LOOKUP:   st_d = lkup_hit_i ? ST_FETCH : ST_WALK1;
      ST_WALK1:    if (rd_done) st_d = rd_ok ? ST_WALK2 : ST_FAULT;
      ST_WALK2:    if (rd_done) st_d = rd_ok ? ST_TBL_INST : ST_FAULT;
      ST_TBL_INST: st_d = ST_FETCH;
      ST_FETCH:    if (rd_done) st_d = rd_ok ? ST_USR_INST : ST_FAULT;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      sent_q     <= 1'b0;
      kern_q     <= 1'b0;
      l2_pfn_q   <= '0;
      tbl_pfn_q  <= '0;
      usr_pfn_q  <= '0;
      usr_prot_q <= '0;
    end else begin
      st_q <= st_d;
      if (mem_req_o) sent_q <= 1'b1;
      else if (rd_done) sent_q <= 1'b0;
      if (accept_o) kern_q <= miss_kern_i;
      if (lkup_o && lkup_hit_i) tbl_pfn_q <= lkup_pfn_i;
      if (rd_done) begin
        case (st_q)
          ST_WALK1: l2_pfn_q <= rd_pfn;
          ST_WALK2: tbl_pfn_q <= rd_pfn;
          ST_FETCH: begin
            usr_pfn_q  <= rd_pfn;
            usr_prot_q <= rdata_i[PROT_W:1];
          end
          default: ;
        endcase
      end
    end
  end

  assign ready_o      = (st_q == ST_IDLE);
  assign accept_o     = ready_o && miss_valid_i;
  assign lkup_o       = (st_q == ST_LOOKUP);
  assign tbl_wr_o     = (st_q == ST_TBL_INST);
  assign usr_wr_o     = (st_q == ST_USR_INST);
  assign resp_valid_o = (st_q == ST_USR_INST) || (st_q == ST_FAULT);
  assign resp_fault_o = (st_q == ST_FAULT);
  assign sel_o        = (st_q == ST_WALK1) ? SEL_L1 : (st_q == ST_WALK2) ? SEL_L2 : SEL_PTE;
  assign kern_o       = kern_q;
  assign l2_pfn_o     = l2_pfn_q;
  assign tbl_pfn_o    = tbl_pfn_q;
  assign usr_pfn_o    = usr_pfn_q;
  assign usr_prot_o   = usr_prot_q;
endmodule

// File: rtl/lpt_refill.sv
module lpt_refill
  import lpt_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [VA_W-1:0]       ptbase_i,
  input  logic [PA_W-1:0]       sysbase_i,
  input  logic                  miss_valid_i,
  input  logic [VA_W-1:0]       miss_va_i,
  input  logic                  miss_kern_i,
  output logic                  miss_ready_o,
  output logic                  resp_valid_o,
  output logic                  resp_fault_o,
  output logic                  tlb_lkup_o,
  output logic [VPN_W-1:0]      tlb_lkup_vpn_o,
  input  logic                  tlb_hit_i,
  input  logic [PA_W-PG_SH-1:0] tlb_hit_pfn_i,
  output logic                  tlb_wr_o,
  output logic [VPN_W-1:0]      tlb_wr_vpn_o,
  output logic [PA_W-PG_SH-1:0] tlb_wr_pfn_o,
  output logic [PROT_W-1:0]     tlb_wr_prot_o,
  output logic                  mem_req_o,
  output logic [PA_W-1:0]       mem_addr_o,
  input  logic                  mem_rvalid_i,
  input  logic [PTE_W-1:0]      mem_rdata_i
);
  localparam int PFN_W = PA_W - PG_SH;

  logic [UVPN_W-1:0] uvpn_q;
  logic              va_ok, accept, tbl_wr, usr_wr, kern;
  addr_sel_e         sel;
  logic [PFN_W-1:0]  l2_pfn, tbl_pfn, usr_pfn;
  logic [PROT_W-1:0] usr_prot;
  logic [VPN_W-1:0]  tbl_vpn;
  logic              unused_va;

  assign unused_va = ^miss_va_i[PG_SH-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) uvpn_q <= '0;
    else if (accept) uvpn_q <= miss_va_i[UVPN_HI:PG_SH];
  end

  lpt_addr_gen #(.PA_W(PA_W)) u_addr (
    .va_hi_i   (miss_va_i[VA_W-1:UVPN_HI+1]),
    .uvpn_i    (uvpn_q),
    .ptbase_i  (ptbase_i),
    .sysbase_i (sysbase_i),
    .l2_pfn_i  (l2_pfn),
    .tbl_pfn_i (tbl_pfn),
    .sel_i     (sel),
    .va_ok_o   (va_ok),
    .tbl_vpn_o (tbl_vpn),
    .addr_o    (mem_addr_o)
  );

  lpt_seq #(.PA_W(PA_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_valid_i (miss_valid_i),
    .miss_kern_i  (miss_kern_i),
    .va_ok_i      (va_ok),
    .lkup_hit_i   (tlb_hit_i),
    .lkup_pfn_i   (tlb_hit_pfn_i),
    .rvalid_i     (mem_rvalid_i),
    .rdata_i      (mem_rdata_i),
    .ready_o      (miss_ready_o),
    .accept_o     (accept),
    .lkup_o       (tlb_lkup_o),
    .mem_req_o    (mem_req_o),
    .sel_o        (sel),
    .tbl_wr_o     (tbl_wr),
    .usr_wr_o     (usr_wr),
    .resp_valid_o (resp_valid_o),
    .resp_fault_o (resp_fault_o),
    .kern_o       (kern),
    .l2_pfn_o     (l2_pfn),
    .tbl_pfn_o    (tbl_pfn),
    .usr_pfn_o    (usr_pfn),
    .usr_prot_o   (usr_prot)
  );

  assign tlb_lkup_vpn_o = tbl_vpn;
  assign tlb_wr_o       = tbl_wr || usr_wr;
  assign tlb_wr_vpn_o   = usr_wr ? VPN_W'(uvpn_q) : tbl_vpn;
  assign tlb_wr_pfn_o   = usr_wr ? usr_pfn : tbl_pfn;
  // table-page protection is synthesised: read-only, kernel bit from faulting mode
  assign tlb_wr_prot_o  = usr_wr ? usr_prot : {kern, 2'b01};
endmodule

// File: rtl/lpt_refill_chk.sv
module lpt_refill_chk
  import lpt_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            miss_valid_i,
  input logic            miss_ready_i,
  input logic [HI_W-1:0] va_hi_i,
  input logic            mem_req_i,
  input logic            mem_rvalid_i,
  input logic            tlb_lkup_i,
  input logic            tlb_wr_i,
  input logic [PROT_W-1:0] tlb_wr_prot_i,
  input logic            resp_valid_i,
  input logic            resp_fault_i
);
  logic pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (mem_req_i) pend_q <= 1'b1;
    else if (mem_rvalid_i) pend_q <= 1'b0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_ready_i |-> (!mem_req_i && !tlb_wr_i && !tlb_lkup_i));
  // R2
  bad_va_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && miss_ready_i && (va_hi_i != '0)) |=> (resp_valid_i && resp_fault_i));
  // R6
  tbl_prot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tlb_wr_i && !resp_valid_i) |-> (tlb_wr_prot_i[1:0] == 2'b01));
  // R7
  ok_with_install_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_i && !resp_fault_i) |-> tlb_wr_i);
  // R8
  fault_no_install_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_i && resp_fault_i) |-> !tlb_wr_i);
  // R9
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |=> !mem_req_i);
  // R9
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> !pend_q);
endmodule

bind lpt_refill lpt_refill_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .miss_valid_i  (miss_valid_i),
  .miss_ready_i  (miss_ready_o),
  .va_hi_i       (miss_va_i[63:43]),
  .mem_req_i     (mem_req_o),
  .mem_rvalid_i  (mem_rvalid_i),
  .tlb_lkup_i    (tlb_lkup_o),
  .tlb_wr_i      (tlb_wr_o),
  .tlb_wr_prot_i (tlb_wr_prot_o),
  .resp_valid_i  (resp_valid_o),
  .resp_fault_i  (resp_fault_o)
);

// File: tb/lpt_refill_test.sv
`timescale 1ns/1ps
module lpt_refill_test;
  localparam int PA_W  = 40;
  localparam int PFN_W = PA_W - 13;
  localparam int TLB_N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [63:0]     ptbase  = 64'hFFFF_FE00_0000_0000;
  logic [PA_W-1:0] sysbase = 40'h00_0010_0000;
  logic            miss_valid = 1'b0;
  logic [63:0]     miss_va = '0;
  logic            miss_kern = 1'b0;
  logic            miss_ready, resp_valid, resp_fault;
  logic            tlb_lkup, tlb_hit, tlb_wr;
  logic [50:0]     tlb_lkup_vpn, tlb_wr_vpn;
  logic [PFN_W-1:0] tlb_hit_pfn, tlb_wr_pfn;
  logic [2:0]      tlb_wr_prot;
  logic            mem_req;
  logic [PA_W-1:0] mem_addr;
  logic            mem_rvalid = 1'b0;
  logic [63:0]     mem_rdata = '0;

  lpt_refill #(.PA_W(PA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ptbase_i(ptbase), .sysbase_i(sysbase),
    .miss_valid_i(miss_valid), .miss_va_i(miss_va), .miss_kern_i(miss_kern),
    .miss_ready_o(miss_ready), .resp_valid_o(resp_valid), .resp_fault_o(resp_fault),
    .tlb_lkup_o(tlb_lkup), .tlb_lkup_vpn_o(tlb_lkup_vpn), .tlb_hit_i(tlb_hit),
    .tlb_hit_pfn_i(tlb_hit_pfn), .tlb_wr_o(tlb_wr), .tlb_wr_vpn_o(tlb_wr_vpn),
    .tlb_wr_pfn_o(tlb_wr_pfn), .tlb_wr_prot_o(tlb_wr_prot), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  int checks = 0;
  int errors = 0;

  // TLB model
  logic [50:0]      t_vpn [TLB_N];
  logic [PFN_W-1:0] t_pfn [TLB_N];
  logic             t_val [TLB_N];
  int               t_wp;

  always_comb begin
    tlb_hit = 1'b0;
    tlb_hit_pfn = '0;
    for (int i = 0; i < TLB_N; i++)
      if (t_val[i] && t_vpn[i] == tlb_lkup_vpn) begin
        tlb_hit = 1'b1;
        tlb_hit_pfn = t_pfn[i];
      end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TLB_N; i++) begin
        t_val[i] <= 1'b0; t_vpn[i] <= '0; t_pfn[i] <= '0;
      end
      t_wp <= 0;
    end else if (tlb_wr) begin
      t_val[t_wp] <= 1'b1;
      t_vpn[t_wp] <= tlb_wr_vpn;
      t_pfn[t_wp] <= tlb_wr_pfn;
      t_wp <= (t_wp + 1) % TLB_N;
    end
  end

  // memory model
  logic [63:0] mem [logic [PA_W-1:0]];
  int lat_cfg = 1;
  int lat_cnt = 0;
  logic [PA_W-1:0] lat_addr = '0;

  function automatic logic [63:0] rd(input logic [PA_W-1:0] a);
    if (mem.exists(a)) return mem[a];
    return '0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      lat_cnt  <= lat_cfg;
      lat_addr <= mem_addr;
    end else if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd(lat_addr);
      end
    end
  end

  // expected event queues: 0 lookup, 1 read, 2 install, 3 response
  int          q_kind[$];
  logic [63:0] q_a[$];
  logic [63:0] q_b[$];
  logic [2:0]  q_c[$];
  string       q_tag[$];

  task automatic push(input int k, input logic [63:0] a, input logic [63:0] b,
                      input logic [2:0] c, input string tag);
    q_kind.push_back(k); q_a.push_back(a); q_b.push_back(b);
    q_c.push_back(c); q_tag.push_back(tag);
  endtask

  task automatic observe(input int k, input logic [63:0] a, input logic [63:0] b,
                         input logic [2:0] c);
    int ek; logic [63:0] ea, eb; logic [2:0] ec; string et;
    checks++;
    if (q_kind.size() == 0) begin
      errors++;
      $display("FAIL R9 unexpected event kind %0d a=%h actual present expected none", k, a);
      return;
    end
    ek = q_kind.pop_front(); ea = q_a.pop_front(); eb = q_b.pop_front();
    ec = q_c.pop_front(); et = q_tag.pop_front();
    if (ek != k || ea != a || eb != b || ec != c) begin
      errors++;
      $display("FAIL %s actual kind=%0d a=%h b=%h c=%b expected kind=%0d a=%h b=%h c=%b",
               et, k, a, b, c, ek, ea, eb, ec);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tlb_lkup)   observe(0, 64'(tlb_lkup_vpn), '0, '0);
      if (mem_req)    observe(1, 64'(mem_addr), '0, '0);
      if (tlb_wr)     observe(2, 64'(tlb_wr_vpn), 64'(tlb_wr_pfn), tlb_wr_prot);
      if (resp_valid) observe(3, '0, '0, {2'b00, resp_fault});
    end
  end

  function automatic logic [63:0] ent_of(input logic [63:0] va);
    return ptbase + {31'b0, va[42:13], 3'b000};
  endfunction

  function automatic logic [63:0] mk_pte(input logic [PA_W-1:0] pa, input logic [2:0] prot);
    return 64'({pa[PA_W-1:13], 13'b0}) | 64'({prot, 1'b1});
  endfunction

  task automatic map_tbl(input logic [63:0] va, input logic [PA_W-1:0] l2pa,
                         input logic [PA_W-1:0] tblpa);
    logic [63:0] ev;
    ev = ent_of(va);
    mem[sysbase + (40'(ev[32:23]) << 3)] = mk_pte(l2pa, 3'b000);
    mem[l2pa + (40'(ev[22:13]) << 3)]    = mk_pte(tblpa, 3'b000);
  endtask

  task automatic set_pte(input logic [63:0] va, input logic [PA_W-1:0] tblpa,
                         input logic [PA_W-1:0] upa, input logic [2:0] prot);
    logic [63:0] ev;
    ev = ent_of(va);
    mem[{tblpa[PA_W-1:13], ev[12:0]}] = mk_pte(upa, prot);
  endtask

  // reference model: expected events from current TLB and memory contents
  task automatic predict(input logic [63:0] va, input logic kern);
    logic [63:0] ev, d;
    logic [PA_W-1:0] a;
    logic [PFN_W-1:0] pfn;
    bit hit;
    if (va[63:43] != '0) begin
      push(3, '0, '0, 3'd1, "R2");
      return;
    end
    ev = ent_of(va);
    push(0, 64'(ev[63:13]), '0, '0, "R3");
    hit = 0; pfn = '0;
    for (int i = 0; i < TLB_N; i++)
      if (t_val[i] && t_vpn[i] == ev[63:13]) begin hit = 1; pfn = t_pfn[i]; end
    if (!hit) begin
      a = sysbase + (40'(ev[32:23]) << 3);
      push(1, 64'(a), '0, '0, "R5");
      d = rd(a);
      if (!d[0]) begin push(3, '0, '0, 3'd1, "R8"); return; end
      a = {d[PA_W-1:13], 13'b0} + (40'(ev[22:13]) << 3);
      push(1, 64'(a), '0, '0, "R5");
      d = rd(a);
      if (!d[0]) begin push(3, '0, '0, 3'd1, "R8"); return; end
      pfn = d[PA_W-1:13];
      push(2, 64'(ev[63:13]), 64'(pfn), {kern, 2'b01}, "R6");
    end
    a = {pfn, ev[12:0]};
    push(1, 64'(a), '0, '0, "R4");
    d = rd(a);
    if (!d[0]) begin push(3, '0, '0, 3'd1, "R8"); return; end
    push(2, 64'(va[42:13]), 64'(d[PA_W-1:13]), d[3:1], "R7");
    push(3, '0, '0, 3'd0, "R7");
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_miss(input logic [63:0] va, input logic kern, input int lat);
    lat_cfg = lat;
    predict(va, kern);
    @(negedge clk);
    miss_valid = 1'b1; miss_va = va; miss_kern = kern;
    @(negedge clk);
    miss_valid = 1'b0;
    chk(miss_ready == 1'b0, "R9 busy", int'(miss_ready), 0);
    while (q_kind.size() != 0) @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(miss_ready == 1'b1, "R9 idle again", int'(miss_ready), 1);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R9 watchdog actual %0d expected below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // memory image
    map_tbl(64'h0000_0000_0000_A000, 40'h00_0020_0000, 40'h00_4000_0000);
    set_pte(64'h0000_0000_0000_A000, 40'h00_4000_0000, 40'h00_0123_4000, 3'b011);
    set_pte(64'h0000_0000_0000_C000, 40'h00_4000_0000, 40'h00_0024_6000, 3'b110);
    set_pte(64'h0000_0000_007F_E000, 40'h00_4000_0000, 40'h09_8000_0000, 3'b001);
    map_tbl(64'h0000_0000_0080_0000, 40'h00_0020_0000, 40'h00_4000_2000);
    set_pte(64'h0000_0000_0080_0000, 40'h00_4000_2000, 40'h00_5555_4000, 3'b111);
    mem[sysbase + 40'd56] = mk_pte(40'h00_0020_4000, 3'b000);

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(miss_ready == 1'b1, "R1 ready", int'(miss_ready), 1);
    chk(mem_req == 1'b0,    "R1 mem_req", int'(mem_req), 0);
    chk(tlb_wr == 1'b0,     "R1 tlb_wr", int'(tlb_wr), 0);
    chk(tlb_lkup == 1'b0,   "R1 tlb_lkup", int'(tlb_lkup), 0);
    chk(resp_valid == 1'b0, "R1 resp", int'(resp_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_req == 1'b0 && tlb_wr == 1'b0, "R1 idle after reset", int'(mem_req), 0);

    do_miss(64'h0000_0000_0000_A000, 1'b0, 1);  // R5 R6 cold nested walk
    do_miss(64'h0000_0000_0000_C000, 1'b0, 2);  // R4 same table page
    do_miss(64'h0000_0000_007F_E000, 1'b1, 3);  // R4 last slot of table page
    do_miss(64'h0000_0000_0080_0000, 1'b1, 2);  // R6 next table page, kernel prot
    do_miss(64'h0000_0000_0080_6000, 1'b0, 1);  // R8 invalid entry
    do_miss(64'h0000_000A_0000_0000, 1'b0, 3);  // R8 invalid first level
    do_miss(64'h0000_000E_0000_0000, 1'b1, 1);  // R8 invalid second level
    do_miss(64'h0000_0800_0000_A000, 1'b0, 1);  // R2 bit 43 set
    do_miss(64'h8000_0000_0000_0000, 1'b1, 1);  // R2 bit 63 set
    do_miss(64'h0000_0000_0000_A000, 1'b0, 2);  // R4 R7 repeat, single fetch

    chk(q_kind.size() == 0, "R9 queue drained", q_kind.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule